// File: doc/BRIEF.md
# Framed Packet Checksum Verifier

This block watches an 8-bit byte stream and picks out framed packets. A packet opens with two fixed marker bytes, 8'h33 and then 8'hCC, back to back. The next byte is a length N. N payload bytes follow, and then one checksum byte. The block adds up the payload bytes modulo 256. When the checksum byte arrives, it compares that byte with the sum. It raises a one-cycle error pulse on a mismatch.

The source changes the bus on the falling clock edge, and the block samples it on the rising edge. A registered payload-valid flag marks the span of cycles in which payload bytes are sampled. The flag never resets the framing and carries no data. Between packets the block hunts for the marker pair, and it ignores every other byte.

Top module: `pkt_sum_check`

## Requirements
- R1: While `rst` is high on a rising edge, `pay_valid` and `sum_err` are low after that edge and the block returns to hunting for 8'h33. This holds even in the middle of a packet.
- R2: A frame starts only when 8'h33 is sampled and 8'hCC is sampled on the very next edge. Any other byte after 8'h33 returns the block to hunting. If that byte is 8'h33 itself, it counts as a fresh first marker.
- R3: The byte sampled on the edge after 8'hCC is taken as the payload length N (0 to 255).
- R4: For N > 0, `pay_valid` goes high on the edge that samples the length byte. It goes low on the edge that samples the last payload byte, so it is high before exactly the N edges that sample payload bytes.
- R5: When the checksum byte differs from the modulo-256 sum of the payload, `sum_err` is high for exactly one cycle after the edge that samples the checksum byte.
- R6: When the checksum byte equals the sum, `sum_err` stays low.
- R7: For N = 0, `pay_valid` stays low, the next byte is the checksum, and the expected checksum is 8'h00.
- R8: After the checksum byte the block hunts again. Bytes outside a frame leave both outputs low, and the next marker pair starts a new packet.
- R9: Payload, length and checksum bytes equal to a marker value do not restart framing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the bus is sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Byte stream, changed on the falling edge |
| pay_valid | output | 1 | High while payload bytes are being sampled |
| sum_err | output | 1 | One-cycle pulse on a checksum mismatch |

## Verification
The stimulus covers several packet shapes, each one separating a different fault:
- Short packets with good and bad checksums separate a correct compare from a stuck or inverted one.
- A 255-byte payload forces the sum to wrap, which separates a true modulo-256 sum.
- Zero-length packets check that the payload state is skipped and that the checksum is compared against zero.
- Noise bytes test the marker hunt: a repeated 8'h33 before 8'hCC, a broken marker pair, and a lone 8'hCC.
- A payload that holds the marker pair shows that framing is not restarted mid-packet.
- A reset in the middle of a packet shows that framing is abandoned.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SYNC2,
    ST_LEN,
    ST_BODY,
    ST_SUM
  } frm_state_t;
endpackage

// File: rtl/pkt_fsm.sv
module pkt_fsm
  import pkt_pkg::*;
#(
  parameter int          W      = 8,
  parameter logic [W-1:0] SYNC_A = 8'h33,
  parameter logic [W-1:0] SYNC_B = 8'hCC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic         acc_clr,
  output logic         acc_add,
  output logic         chk_en,
  output logic         valid_o
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  frm_state_t   state_q, state_d;
  logic [W-1:0] cnt_q;
  logic         valid_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_HUNT:  if (din == SYNC_A) state_d = ST_SYNC2;
      ST_SYNC2: begin
        if (din == SYNC_B)      state_d = ST_LEN;
        else if (din == SYNC_A) state_d = ST_SYNC2;
        else                    state_d = ST_HUNT;
      end
      ST_LEN:   state_d = (din == ZERO) ? ST_SUM : ST_BODY;
      ST_BODY:  if (cnt_q == ONE) state_d = ST_SUM;
      ST_SUM:   state_d = ST_HUNT;
      default:  state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HUNT;
      cnt_q   <= ZERO;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      case (state_q)
        ST_LEN: begin
          cnt_q   <= din;
          valid_q <= (din != ZERO);
        end
        ST_BODY: begin
          cnt_q <= cnt_q - ONE;
          if (cnt_q == ONE) valid_q <= 1'b0;
        end
        default: valid_q <= 1'b0;
      endcase
    end
  end

  assign acc_clr = (state_q == ST_LEN);
  assign acc_add = (state_q == ST_BODY);
  assign chk_en  = (state_q == ST_SUM);
  assign valid_o = valid_q;
endmodule

// File: rtl/pkt_accum.sv
module pkt_accum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         add,
  input  logic [W-1:0] din,
  output logic [W-1:0] sum
);
  logic [W-1:0] sum_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  sum_q <= '0;
    else if (add)    sum_q <= sum_q + din;
  end

  assign sum = sum_q;
endmodule

// File: rtl/pkt_cmp.sv
module pkt_cmp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         chk_en,
  input  logic [W-1:0] sum,
  input  logic [W-1:0] din,
  output logic         err
);
  logic err_q;

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= chk_en && (sum != din);
  end

  assign err = err_q;
endmodule

// File: rtl/pkt_sum_check.sv
module pkt_sum_check #(
  parameter int          W      = 8,
  parameter logic [W-1:0] SYNC_A = 8'h33,
  parameter logic [W-1:0] SYNC_B = 8'hCC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic         pay_valid,
  output logic         sum_err
);
  logic         acc_clr, acc_add, chk_en;
  logic [W-1:0] sum;

  pkt_fsm #(.W(W), .SYNC_A(SYNC_A), .SYNC_B(SYNC_B)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .din     (din),
    .acc_clr (acc_clr),
    .acc_add (acc_add),
    .chk_en  (chk_en),
    .valid_o (pay_valid)
  );

  pkt_accum #(.W(W)) u_acc (
    .clk (clk),
    .rst (rst),
    .clr (acc_clr),
    .add (acc_add),
    .din (din),
    .sum (sum)
  );

  pkt_cmp #(.W(W)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .chk_en (chk_en),
    .sum    (sum),
    .din    (din),
    .err    (sum_err)
  );
endmodule

// File: rtl/pkt_sum_check_sva.sv
module pkt_sum_check_sva #(
  parameter int          W      = 8,
  parameter logic [W-1:0] SYNC_A = 8'h33,
  parameter logic [W-1:0] SYNC_B = 8'hCC
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] din,
  input logic         pay_valid,
  input logic         sum_err
);
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sum_err |=> !sum_err);  // R5

  AST_ERR_OUTSIDE_BODY: assert property (@(posedge clk) disable iff (rst)
    sum_err |-> !pay_valid);  // R4

  AST_BODY_AFTER_MARKERS: assert property (@(posedge clk) disable iff (rst)
    $rose(pay_valid) |-> ($past(din, 2) == SYNC_B && $past(din, 3) == SYNC_A));  // R2

  AST_BODY_NONZERO_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(pay_valid) |-> ($past(din) != '0));  // R7

  AST_ERR_AFTER_BODY: assert property (@(posedge clk) disable iff (rst)
    $rose(sum_err) |-> !$past(pay_valid));  // R5
endmodule

bind pkt_sum_check pkt_sum_check_sva #(.W(W), .SYNC_A(SYNC_A), .SYNC_B(SYNC_B)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .din       (din),
  .pay_valid (pay_valid),
  .sum_err   (sum_err)
);

// File: tb/test_pkt_sum_check.sv
module test_pkt_sum_check;
  localparam int CLK_P   = 10;
  localparam int WD_MAX  = 20000;
  localparam logic [7:0] MA = 8'h33;
  localparam logic [7:0] MB = 8'hCC;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = 8'h00;
  logic       pay_valid, sum_err;
  int         n_chk = 0;
  int         n_bad = 0;
  int         cyc   = 0;

  pkt_sum_check i_pkt_sum_check (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .pay_valid (pay_valid),
    .sum_err   (sum_err)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_MAX) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected < %0d", cyc, WD_MAX);
      finish_run();
    end
  end

  task automatic check(input logic ev, input logic ee, input string tag);
    n_chk++;
    if (pay_valid !== ev || sum_err !== ee) begin
      n_bad++;
      $display("FAIL %s: actual valid=%b err=%b expected valid=%b err=%b",
               tag, pay_valid, sum_err, ev, ee);
    end
  endtask

  // Drive one byte on the falling edge; check outputs just after the sampling edge.
  task automatic step(input logic [7:0] b, input logic ev, input logic ee, input string tag);
    @(negedge clk);
    din = b;
    @(posedge clk);
    #1;
    check(ev, ee, tag);
  endtask

  task automatic send_pkt(input int len, input int seed, input bit bad, input bit mark_body);
    int sum = 0;
    logic [7:0] cs;
    step(MA, 1'b0, 1'b0, "R2");
    step(MB, 1'b0, 1'b0, "R2");
    step(8'(len), len != 0, 1'b0, "R3");
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'((i * 37 + seed * 11 + 5) & 255);
      if (mark_body && i == 0) b = MA;
      if (mark_body && i == 1) b = MB;
      sum += b;
      step(b, i != len - 1, 1'b0, mark_body ? "R9" : "R4");
    end
    cs = 8'(sum & 255) ^ (bad ? 8'h5A : 8'h00);
    step(cs, 1'b0, bad, bad ? "R5" : (len == 0 ? "R7" : "R6"));
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(1'b0, 1'b0, "R1 reset state");
    @(negedge clk);
    rst = 1'b0;

    send_pkt(3, 1, 1'b0, 1'b0);   // good short
    send_pkt(4, 2, 1'b1, 1'b0);   // bad short
    step(8'h00, 1'b0, 1'b0, "R8");
    step(8'h00, 1'b0, 1'b0, "R8"); // R6 companion: no pulse remains
    send_pkt(0, 0, 1'b0, 1'b0);   // zero length, checksum 00
    send_pkt(0, 0, 1'b1, 1'b0);   // zero length, wrong checksum

    // R2: repeated first marker re-arms
    step(MA, 1'b0, 1'b0, "R2");
    send_pkt(2, 3, 1'b0, 1'b0);
    // R2: broken pair, then lone second marker and noise
    step(MA, 1'b0, 1'b0, "R2");
    step(8'h55, 1'b0, 1'b0, "R2");
    step(MB, 1'b0, 1'b0, "R2");
    step(8'h02, 1'b0, 1'b0, "R2");
    step(8'hA1, 1'b0, 1'b0, "R8");
    // R9: markers inside payload
    send_pkt(5, 4, 1'b1, 1'b1);
    send_pkt(6, 5, 1'b0, 1'b1);
    // R5: long payload with wraparound, good then bad
    send_pkt(255, 6, 1'b0, 1'b0);
    send_pkt(255, 7, 1'b1, 1'b0);
    // R8: back to back with no gap
    send_pkt(1, 8, 1'b1, 1'b0);
    send_pkt(1, 9, 1'b0, 1'b0);

    // R1: reset in the middle of a packet
    step(MA, 1'b0, 1'b0, "R2");
    step(MB, 1'b0, 1'b0, "R2");
    step(8'd6, 1'b1, 1'b0, "R3");
    step(8'h10, 1'b1, 1'b0, "R4");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(1'b0, 1'b0, "R1 mid-packet reset");
    @(negedge clk);
    rst = 1'b0;
    din = 8'h00;
    step(8'h07, 1'b0, 1'b0, "R1 hunting after reset");
    send_pkt(2, 10, 1'b1, 1'b0);

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule